// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches a bank of asynchronous general-purpose inputs and turns selected conditions on them into interrupt events. Every pin is first brought into the clock domain through a short synchronizer chain. One more register keeps the sample from the previous cycle, so that edges can be seen. Each pin has its own control word. A 4-bit mode code in that word picks how the pin is watched: a low level, a high level, a rising edge, a falling edge, either edge, or nothing at all.

Detected events set one flag per pin in a shared status word. Software clears a flag by writing a one to its bit. One registered interrupt line goes high while any flag is set. In a level mode the flag is set again on every cycle the level holds, so it cannot be cleared for good while the condition lasts. When a new event and a clear reach the same bit in the same cycle, the event wins and the flag stays set.

Software reaches the control words and the status word through a simple 32-bit register port with separate read and write strobes. Read data comes back one cycle after the read strobe, marked by a valid pulse.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every control word reads 0, the status word reads 0 and `irq_out` is 0.
- R2: The control word of pin i sits at byte offset 4*i. Its mode code is stored in bits 19:16 and reads back there. All other bits are ignored on write and read as 0.
- R3: Mode code 0x9 sets the pin's flag when the synchronized input goes from 0 to 1, and not when it goes from 1 to 0.
- R4: Mode code 0xA sets the pin's flag when the synchronized input goes from 1 to 0, and not when it goes from 0 to 1.
- R5: Mode code 0xB sets the pin's flag on a transition in either direction.
- R6: Mode code 0x8 sets the flag on every cycle the input is 0. A clear written while the input stays 0 leaves the flag set.
- R7: Mode code 0xC sets the flag on every cycle the input is 1. A clear written while the input stays 1 leaves the flag set.
- R8: Code 0x0 and every code not named in R3 to R7 (for example 0x1 or 0xF) never set a flag. Writing 0 to a control word stops further events for that pin.
- R9: The status word is at byte offset 0xA0 and holds the flag of pin i in bit i. Writing a 1 to a bit clears that flag. Bits written as 0 keep their state, and writing all ones clears every flag.
- R10: If an event and a clear reach the same flag in the same cycle, the flag is set after that cycle.
- R11: `irq_out` is 1 exactly when at least one status flag is set. It changes in the same cycle as the status word.
- R12: `bus_rvalid` and `bus_rdata` appear one cycle after `bus_rd`. Any offset that is neither a control word nor the status word reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 32 | Asynchronous GPIO inputs, one bit per pin |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| irq_out | output | 1 | Combined interrupt, high while any flag is set |

## Verification
An interrupt event and a software clear of the status word can reach the same flag in the same cycle. The bench provokes this in two ways. First, it holds a level-high and a level-low pin in their active state and writes a clear; the level still holds, so the flag must read back as 1. Second, it times a status clear so that the write is sampled on exactly the clock edge where a rising-edge event on an already-set pin is recorded. It judges the result by reading back the flag, expecting 1, and then by a second clear with no event pending, expecting 0.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [3:0] {
    MODE_OFF  = 4'h0,
    MODE_LOW  = 4'h8,
    MODE_RISE = 4'h9,
    MODE_FALL = 4'hA,
    MODE_BOTH = 4'hB,
    MODE_HIGH = 4'hC
  } irq_mode_e;

  localparam int MODE_W   = 4;
  localparam int MODE_LSB = 16;
  localparam logic [7:0] STATUS_OFFSET = 8'hA0;

  function automatic logic mode_is_valid(logic [MODE_W-1:0] code);
    return (code == MODE_LOW) || (code == MODE_RISE) || (code == MODE_FALL) ||
           (code == MODE_BOTH) || (code == MODE_HIGH);
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] cur_q,
  output logic [WIDTH-1:0] prev_q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= raw_in;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign cur_q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [MODE_W-1:0]          wr_mode,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [MODE_W-1:0]          rd_mode,
  output logic [NUM_PINS*MODE_W-1:0] mode_flat
);

  logic [MODE_W-1:0] mode_q [NUM_PINS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PINS; p++) mode_q[p] <= MODE_OFF;
    end else if (wr_en) begin
      mode_q[wr_idx] <= wr_mode;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_flat
      assign mode_flat[g*MODE_W +: MODE_W] = mode_q[g];
    end
  endgenerate

  assign rd_mode = mode_q[rd_idx];

  // R2: a written code is the one held from the next cycle on
  p_cfg_store_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (mode_q[$past(wr_idx)] == $past(wr_mode)));

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PINS*MODE_W-1:0] mode_flat,
  input  logic [NUM_PINS-1:0]        cur,
  input  logic [NUM_PINS-1:0]        prev,
  output logic [NUM_PINS-1:0]        evt
);

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_pin
      logic [MODE_W-1:0] code;
      assign code = mode_flat[g*MODE_W +: MODE_W];

      always_comb begin
        unique case (code)
          MODE_LOW:  evt[g] = ~cur[g];
          MODE_HIGH: evt[g] = cur[g];
          MODE_RISE: evt[g] = cur[g] & ~prev[g];
          MODE_FALL: evt[g] = ~cur[g] & prev[g];
          MODE_BOTH: evt[g] = cur[g] ^ prev[g];
          default:   evt[g] = 1'b0;
        endcase
      end

      // R8: no event comes from a disabled or unlisted code
      p_quiet_mode_r8: assert property (@(posedge clk) disable iff (rst)
        evt[g] |-> mode_is_valid(code));

      // R3, R4, R5: an edge-mode event needs the input to have moved
      p_edge_moved_r5: assert property (@(posedge clk) disable iff (rst)
        (evt[g] && (code inside {MODE_RISE, MODE_FALL, MODE_BOTH})) |-> (cur[g] != prev[g]));
    end
  endgenerate

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] evt,
  input  logic                clr_en,
  input  logic [NUM_PINS-1:0] clr_mask,
  output logic [NUM_PINS-1:0] status_q,
  output logic                irq_q
);

  logic [NUM_PINS-1:0] clr_eff;
  logic [NUM_PINS-1:0] status_d;

  assign clr_eff  = clr_en ? clr_mask : '0;
  // set has priority over clear
  assign status_d = (status_q & ~clr_eff) | evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= |status_d;
    end
  end

  // R10: every event leaves its flag set, clear or not
  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & $past(evt)) == $past(evt)));

  // R9: a cleared bit without a competing event reads 0
  p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & $past(clr_eff & ~evt)) == '0));

  // R9: bits neither cleared nor set keep their value
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & ~$past(evt | clr_eff)) == ($past(status_q) & ~$past(evt | clr_eff))));

  // R11: the line only drops after a clear write
  p_irq_drop_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_q) |-> $past(clr_en));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  localparam int IDX_W      = $clog2(NUM_PINS),
  localparam int CTL_WORDS  = NUM_PINS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_rvalid,
  output logic                irq_out
);

  logic [NUM_PINS-1:0]        cur, prev, evt, status;
  logic [NUM_PINS*MODE_W-1:0] mode_flat;
  logic [MODE_W-1:0]          rd_mode;
  logic [IDX_W-1:0]           idx;
  logic                       ctl_hit, sts_hit;
  logic [DATA_W-1:0]          rd_word;

  // decode
  assign idx     = bus_addr[IDX_W+1:2];
  assign ctl_hit = (bus_addr[1:0] == 2'b00) &&
                   (int'(bus_addr[ADDR_W-1:2]) < CTL_WORDS);
  assign sts_hit = (bus_addr == STATUS_OFFSET[ADDR_W-1:0]);

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw_in (pin_in),
    .cur_q  (cur),
    .prev_q (prev)
  );

  gpio_pin_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bus_wr && ctl_hit),
    .wr_idx    (idx),
    .wr_mode   (bus_wdata[MODE_LSB +: MODE_W]),
    .rd_idx    (idx),
    .rd_mode   (rd_mode),
    .mode_flat (mode_flat)
  );

  gpio_evt_detect #(.NUM_PINS(NUM_PINS)) u_det (
    .clk       (clk),
    .rst       (rst),
    .mode_flat (mode_flat),
    .cur       (cur),
    .prev      (prev),
    .evt       (evt)
  );

  gpio_irq_status #(.NUM_PINS(NUM_PINS)) u_sts (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .clr_en   (bus_wr && sts_hit),
    .clr_mask (bus_wdata[NUM_PINS-1:0]),
    .status_q (status),
    .irq_q    (irq_out)
  );

  // read mux
  always_comb begin
    rd_word = '0;
    if (ctl_hit)      rd_word[MODE_LSB +: MODE_W] = rd_mode;
    else if (sts_hit) rd_word[NUM_PINS-1:0]       = status;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_word;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  // R12: read data follows the strobe by one cycle
  p_rd_latency_r12: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  // R11: the line rises only after an event
  p_irq_cause_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> $past(|evt));

endmodule

// File: tb/tb_gpio_irq_detect.sv
module tb_gpio_irq_detect;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pin_in = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq_out;

  int n_tests = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  string       q_tag[$];
  logic [31:0] q_val[$];

  gpio_irq_detect dut (
    .clk, .rst, .pin_in, .bus_wr, .bus_rd, .bus_addr,
    .bus_wdata, .bus_rdata, .bus_rvalid, .irq_out
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as read data arrives
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (q_tag.size() == 0) chk("R12 unexpected rvalid", 32'd1, 32'd0);
      else chk(q_tag.pop_front(), bus_rdata, q_val.pop_front());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: pushes the expected value then issues the read
  task automatic bus_read(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    q_tag.push_back(tag); q_val.push_back(exp);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_pin(int p, logic v);
    @(negedge clk);
    pin_in[p] = v;
    idle(4);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    bus_read(8'h00, 32'h0, "R1 ctl0");
    bus_read(8'h7C, 32'h0, "R1 ctl31");
    bus_read(8'hA0, 32'h0, "R1 status");
    chk("R1 irq", {31'b0, irq_out}, 32'h0);

    // R2 field placement, other bits dropped
    bus_write(8'h14, 32'hFFFF_FFFF);
    bus_read(8'h14, 32'h000F_0000, "R2 ctl5 field");
    bus_write(8'h14, 32'h0);
    bus_write(8'h00, 32'h0009_0000);
    bus_read(8'h00, 32'h0009_0000, "R2 ctl0 rise");

    // R3 rising on pin0
    set_pin(0, 1'b1);
    bus_read(8'hA0, 32'h1, "R3 rise sets");
    chk("R11 irq high", {31'b0, irq_out}, 32'h1);
    bus_write(8'hA0, 32'h1);
    bus_read(8'hA0, 32'h0, "R9 clear pin0");
    chk("R11 irq low", {31'b0, irq_out}, 32'h0);
    set_pin(0, 1'b0);
    bus_read(8'hA0, 32'h0, "R3 fall ignored");

    // R4 falling on pin1
    bus_write(8'h04, 32'h000A_0000);
    set_pin(1, 1'b1);
    bus_read(8'hA0, 32'h0, "R4 rise ignored");
    set_pin(1, 1'b0);
    bus_read(8'hA0, 32'h2, "R4 fall sets");
    bus_write(8'hA0, 32'h2);

    // R5 either edge on pin2
    bus_write(8'h08, 32'h000B_0000);
    set_pin(2, 1'b1);
    bus_read(8'hA0, 32'h4, "R5 up sets");
    bus_write(8'hA0, 32'h4);
    set_pin(2, 1'b0);
    bus_read(8'hA0, 32'h4, "R5 down sets");
    bus_write(8'hA0, 32'h4);
    bus_read(8'hA0, 32'h0, "R5 cleared");

    // R7 level high on pin3, clear cannot stick
    bus_write(8'h0C, 32'h000C_0000);
    set_pin(3, 1'b1);
    bus_read(8'hA0, 32'h8, "R7 high sets");
    bus_write(8'hA0, 32'h8);
    bus_read(8'hA0, 32'h8, "R7/R10 clear while high");
    set_pin(3, 1'b0);
    bus_write(8'hA0, 32'h8);
    bus_read(8'hA0, 32'h0, "R7 clear after low");

    // R6 level low on pin4 (pin already 0)
    bus_write(8'h10, 32'h0008_0000);
    idle(3);
    bus_read(8'hA0, 32'h10, "R6 low sets");
    bus_write(8'hA0, 32'h10);
    bus_read(8'hA0, 32'h10, "R6/R10 clear while low");
    set_pin(4, 1'b1);
    bus_write(8'hA0, 32'h10);
    bus_read(8'hA0, 32'h0, "R6 clear after high");

    // R8 disabled and unlisted codes, and masking by writing 0
    bus_write(8'h18, 32'h000F_0000);
    bus_write(8'h1C, 32'h0001_0000);
    bus_write(8'h0C, 32'h0);
    set_pin(6, 1'b1); set_pin(7, 1'b1); set_pin(8, 1'b1); set_pin(3, 1'b1);
    set_pin(6, 1'b0); set_pin(7, 1'b0); set_pin(8, 1'b0);
    bus_read(8'hA0, 32'h0, "R8 no flags");
    chk("R8 irq quiet", {31'b0, irq_out}, 32'h0);

    // R9 partial clears on pins 10, 20, 31
    bus_write(8'h28, 32'h0009_0000);
    bus_write(8'h50, 32'h0009_0000);
    bus_write(8'h7C, 32'h0009_0000);
    @(negedge clk) begin pin_in[10] = 1'b1; pin_in[20] = 1'b1; pin_in[31] = 1'b1; end
    idle(4);
    bus_read(8'hA0, 32'h8010_0400, "R9 three set");
    bus_write(8'hA0, 32'h0);
    bus_read(8'hA0, 32'h8010_0400, "R9 zeros keep");
    bus_write(8'hA0, 32'h0010_0000);
    bus_read(8'hA0, 32'h8000_0400, "R9 one cleared");
    bus_write(8'hA0, 32'hFFFF_FFFF);
    bus_read(8'hA0, 32'h0, "R9 all cleared");
    chk("R11 irq after clear all", {31'b0, irq_out}, 32'h0);

    // R10 edge event and clear on the same edge (pin0 rising)
    set_pin(0, 1'b1);
    set_pin(0, 1'b0);
    bus_read(8'hA0, 32'h1, "R10 pre-set");
    @(negedge clk) pin_in[0] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    bus_write(8'hA0, 32'h1);
    bus_read(8'hA0, 32'h1, "R10 set wins");
    bus_write(8'hA0, 32'h1);
    bus_read(8'hA0, 32'h0, "R10 later clear");

    // R12 unmapped offsets
    bus_read(8'h90, 32'h0, "R12 unmapped");
    bus_read(8'h06, 32'h0, "R12 misaligned");
    bus_read(8'hA4, 32'h0, "R12 past status");

    idle(4);
    chk("R12 all reads answered", q_tag.size(), 32'd0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule